// File: doc/BRIEF.md
# Supply Supervisor Reset with Chip-Select Watchdog

This block produces a system reset from two sources. The first is a digital flag that reports the supply as below its minimum sense level. The second is a watchdog that monitors a chip-select line. While the flag is high the reset is asserted at once. After the flag clears, the reset stays asserted until the supply has stayed good for a set number of clock cycles. That cycle count stands in for a hold-off time of about 200 ms once it is scaled to the clock.

When the watchdog is enabled, only a falling edge of chip-select restarts it. If the line stays high, or stays low, for longer than the timeout, the block emits a reset pulse of fixed width and then starts watching again. Chip-select passes through a synchroniser before edge detection. The supply flag must be synchronous to `clk_i` and must be high at power-up, because it also clears every counter. A parameter chooses whether the reset output is active-low or active-high. All pins are plain control levels, so no stream handshake applies.

Top module: `vsup_reset_gen`

## Requirements
- R1: While `supply_low_i` is 1, the reset is asserted in the same cycle, whatever the other inputs and the internal state.
- R2: After `supply_low_i` returns to 0 and stays at 0, the reset releases exactly `PG_DELAY_CYC` rising clock edges later.
- R3: If `supply_low_i` rises again before the hold-off expires, the hold-off restarts from zero. Release then comes `PG_DELAY_CYC` edges after the final clear of the flag.
- R4: With the watchdog enabled and `cs_n_i` held high, the reset pulse begins `WD_TIMEOUT_CYC` edges after the watchdog starts counting. Counting starts at supply release or at the end of the previous pulse.
- R5: With `cs_n_i` held low after a falling edge, the watchdog still times out. The falling edge restarts the count on the third rising edge after the pin falls (two synchroniser flops plus one history flop), and the pulse begins `WD_TIMEOUT_CYC` edges after that restart.
- R6: Each falling edge of `cs_n_i` restarts the watchdog count. A rising edge has no effect on the count.
- R7: A watchdog pulse lasts exactly `WD_PULSE_CYC` cycles. After it, the count starts again from zero.
- R8: While `wd_en_i` is 0, the watchdog never fires and its count is held at zero. After enable, a full `WD_TIMEOUT_CYC` edges pass before a pulse.
- R9: With `ACTIVE_LOW` = 1, the asserted level of `rst_o` is 0. With `ACTIVE_LOW` = 0, the asserted level is 1.
- R10: The watchdog is held cleared while the supply reset (flag or hold-off) is active, so it cannot fire during the hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| supply_low_i | input | 1 | 1 = supply below its sense level; synchronous to clk_i; also clears all state |
| cs_n_i | input | 1 | Monitored chip-select line (asynchronous) |
| wd_en_i | input | 1 | 1 = watchdog enabled |
| rst_o | output | 1 | Reset output; polarity set by ACTIVE_LOW |

## Verification
The hardest case to reach from the pins is a watchdog timeout while chip-select is held low. That case needs a falling edge first, and the restart it causes lands three clock edges later because of the synchroniser. The stimulus drops the pin at a known negative edge and counts edges from there. It then raises the pin partway through the window and shows that the rising edge leaves the pulse time unchanged. A second hard case is a supply dip in the middle of the hold-off, which is produced by a one-cycle pulse on the flag halfway through the delay.

// File: rtl/vsup_pkg.sv
package vsup_pkg;
  typedef enum logic {
    WD_WATCH = 1'b0,
    WD_FIRE  = 1'b1
  } wd_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/vsup_cs_edge.sv
module vsup_cs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic cs_n_i,
  output logic fall_o
);
  logic [STAGES:0] chain;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (clr_i) chain[g] <= 1'b1;
        else       chain[g] <= cs_n_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (clr_i) chain[g] <= 1'b1;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/vsup_pg_delay.sv
module vsup_pg_delay #(
  parameter int unsigned DELAY_CYC = 64
) (
  input  logic clk_i,
  input  logic supply_low_i,
  output logic ok_o
);
  localparam int unsigned CW = vsup_pkg::cnt_width(DELAY_CYC);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (supply_low_i)        cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == LIMIT);
endmodule

// File: rtl/vsup_wdog.sv
module vsup_wdog #(
  parameter int unsigned TIMEOUT_CYC = 40,
  parameter int unsigned PULSE_CYC   = 8
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic kick_i,
  output logic fire_o
);
  import vsup_pkg::*;

  localparam int unsigned TW = cnt_width(TIMEOUT_CYC);
  localparam int unsigned PW = cnt_width(PULSE_CYC);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [PW-1:0] P_LAST = PW'(PULSE_CYC - 1);

  wd_state_e     state_q;
  logic [TW-1:0] tcnt_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      state_q <= WD_WATCH;
      tcnt_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      unique case (state_q)
        WD_WATCH: begin
          if (kick_i) begin
            tcnt_q <= '0;
          end else if (tcnt_q == T_LAST) begin
            state_q <= WD_FIRE;
            tcnt_q  <= '0;
            pcnt_q  <= '0;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        WD_FIRE: begin
          if (pcnt_q == P_LAST) begin
            state_q <= WD_WATCH;
            tcnt_q  <= '0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: state_q <= WD_WATCH;
      endcase
    end
  end

  assign fire_o = (state_q == WD_FIRE);
endmodule

// File: rtl/vsup_reset_gen.sv
module vsup_reset_gen #(
  parameter int unsigned PG_DELAY_CYC   = 64,
  parameter int unsigned WD_TIMEOUT_CYC = 40,
  parameter int unsigned WD_PULSE_CYC   = 8,
  parameter int          SYNC_STAGES    = 2,
  parameter bit          ACTIVE_LOW     = 1'b1
) (
  input  logic clk_i,
  input  logic supply_low_i,
  input  logic cs_n_i,
  input  logic wd_en_i,
  output logic rst_o
);
  logic pg_ok;
  logic sup_hold;
  logic wd_clr;
  logic cs_fall;
  logic wd_fire;
  logic rst_act;

  vsup_pg_delay #(.DELAY_CYC(PG_DELAY_CYC)) u_pg (
    .clk_i        (clk_i),
    .supply_low_i (supply_low_i),
    .ok_o         (pg_ok)
  );

  assign sup_hold = supply_low_i | ~pg_ok;
  assign wd_clr   = sup_hold | ~wd_en_i;

  vsup_cs_edge #(.STAGES(SYNC_STAGES)) u_cs (
    .clk_i  (clk_i),
    .clr_i  (sup_hold),
    .cs_n_i (cs_n_i),
    .fall_o (cs_fall)
  );

  vsup_wdog #(
    .TIMEOUT_CYC (WD_TIMEOUT_CYC),
    .PULSE_CYC   (WD_PULSE_CYC)
  ) u_wd (
    .clk_i  (clk_i),
    .clr_i  (wd_clr),
    .kick_i (cs_fall),
    .fire_o (wd_fire)
  );

  assign rst_act = sup_hold | wd_fire;

  if (ACTIVE_LOW) begin : g_low
    assign rst_o = ~rst_act;
  end else begin : g_high
    assign rst_o = rst_act;
  end
endmodule

// File: rtl/vsup_reset_chk.sv
module vsup_reset_chk #(
  parameter int unsigned PG_DELAY_CYC = 64,
  parameter int unsigned WD_PULSE_CYC = 8,
  parameter bit          ACTIVE_LOW   = 1'b1
) (
  input logic clk_i,
  input logic supply_low_i,
  input logic wd_en_i,
  input logic rst_o,
  input logic pg_ok,
  input logic wd_fire,
  input logic cs_fall
);
  localparam logic ASSERT_LVL = ~ACTIVE_LOW;

  int unsigned good_run;
  int unsigned fire_len;

  always_ff @(posedge clk_i) begin
    if (supply_low_i)                 good_run <= 0;
    else if (good_run < PG_DELAY_CYC) good_run <= good_run + 1;
    if (supply_low_i || !wd_fire)     fire_len <= 0;
    else                              fire_len <= fire_len + 1;
  end

  p_low_asserts_r1: assert property (@(posedge clk_i)
    supply_low_i |-> rst_o == ASSERT_LVL);

  p_release_time_r2: assert property (@(posedge clk_i) disable iff (supply_low_i)
    $rose(pg_ok) |-> good_run == PG_DELAY_CYC);

  p_kick_holds_off_r6: assert property (@(posedge clk_i) disable iff (supply_low_i)
    (cs_fall && !wd_fire && wd_en_i && pg_ok) |=> !wd_fire);

  p_pulse_width_r7: assert property (@(posedge clk_i) disable iff (supply_low_i)
    ($fell(wd_fire) && $past(wd_en_i) && $past(pg_ok)) |-> fire_len == WD_PULSE_CYC);

  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (supply_low_i)
    (!wd_en_i && $past(!wd_en_i)) |-> !wd_fire);

  p_hold_blocks_wd_r10: assert property (@(posedge clk_i) disable iff (supply_low_i)
    !pg_ok |-> !wd_fire);
endmodule

bind vsup_reset_gen vsup_reset_chk #(
  .PG_DELAY_CYC (PG_DELAY_CYC),
  .WD_PULSE_CYC (WD_PULSE_CYC),
  .ACTIVE_LOW   (ACTIVE_LOW)
) u_chk (
  .clk_i        (clk_i),
  .supply_low_i (supply_low_i),
  .wd_en_i      (wd_en_i),
  .rst_o        (rst_o),
  .pg_ok        (pg_ok),
  .wd_fire      (wd_fire),
  .cs_fall      (cs_fall)
);

// File: tb/sim_vsup_reset_gen.sv
module sim_vsup_reset_gen;
  localparam time CLK_PERIOD = 10ns;
  localparam int PG = 64;
  localparam int T  = 40;
  localparam int P  = 8;

  logic clk = 1'b0;
  logic supply_low, cs_n, wd_en;
  logic rst_l, rst_h;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsup_reset_gen #(.PG_DELAY_CYC(PG), .WD_TIMEOUT_CYC(T), .WD_PULSE_CYC(P),
                   .ACTIVE_LOW(1'b1)) u0 (
    .clk_i(clk), .supply_low_i(supply_low), .cs_n_i(cs_n), .wd_en_i(wd_en), .rst_o(rst_l));

  vsup_reset_gen #(.PG_DELAY_CYC(PG), .WD_TIMEOUT_CYC(T), .WD_PULSE_CYC(P),
                   .ACTIVE_LOW(1'b0)) u1 (
    .clk_i(clk), .supply_low_i(supply_low), .cs_n_i(cs_n), .wd_en_i(wd_en), .rst_o(rst_h));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R9: active-low copy must equal ~active, active-high copy must equal active
  task automatic expect_rst(input bit active, input string req);
    tests++;
    if (rst_l !== ~active) begin
      fails++;
      $display("FAIL %s (R9 low pol): rst_o actual=%b expected=%b", req, rst_l, ~active);
    end
    tests++;
    if (rst_h !== active) begin
      fails++;
      $display("FAIL %s (R9 high pol): rst_o actual=%b expected=%b", req, rst_h, active);
    end
  endtask

  task automatic quiet_for(input int n, input string req);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (rst_h !== 1'b0 || rst_l !== 1'b1) bad = 1;
    end
    tests++;
    if (bad) begin
      fails++;
      $display("FAIL %s: reset seen in quiet window actual=1 expected=0", req);
    end
  endtask

  task automatic t_reset_state();
    supply_low = 1'b1; cs_n = 1'b1; wd_en = 1'b1;
    step(5);
    expect_rst(1'b1, "R1 supply low");
    cs_n = 1'b0; step(3);
    expect_rst(1'b1, "R1 supply low, cs toggled");
    cs_n = 1'b1; step(3);
  endtask

  task automatic t_pg_release();
    supply_low = 1'b0;
    step(PG - 1);
    expect_rst(1'b1, "R2 one edge before release");
    step(1);
    expect_rst(1'b0, "R2 release");
    step(T - 1);
    expect_rst(1'b0, "R10 wd cleared during hold-off");
  endtask

  task automatic t_stuck_high();
    step(1);
    expect_rst(1'b1, "R4 timeout with cs high");
    step(P - 1);
    expect_rst(1'b1, "R7 pulse last cycle");
    step(1);
    expect_rst(1'b0, "R7 pulse end");
    step(T - 1);
    expect_rst(1'b0, "R7 restart before timeout");
    step(1);
    expect_rst(1'b1, "R7 restarted count times out");
    step(P);
    expect_rst(1'b0, "R7 second pulse end");
  endtask

  task automatic t_stuck_low();
    cs_n = 1'b0;
    step(T + 2);
    expect_rst(1'b0, "R5 cs low, before timeout");
    step(1);
    expect_rst(1'b1, "R5 cs low timeout");
    step(P);
    expect_rst(1'b0, "R5 pulse end");
  endtask

  task automatic t_kick();
    cs_n = 1'b1; step(2);
    for (int k = 0; k < 8; k++) begin
      cs_n = 1'b0;
      quiet_for(T/4, "R6 periodic falls keep watchdog quiet");
      cs_n = 1'b1;
      quiet_for(T/4, "R6 periodic falls keep watchdog quiet");
    end
    cs_n = 1'b0;
    step(5);
    cs_n = 1'b1;
    step(T + 3 - 5 - 1);
    expect_rst(1'b0, "R6 rising edge does not restart (before)");
    step(1);
    expect_rst(1'b1, "R6 rising edge does not restart (fire)");
    step(P);
    expect_rst(1'b0, "R6 pulse end");
  endtask

  task automatic t_disable();
    wd_en = 1'b0;
    quiet_for(3*T, "R8 disabled watchdog stays quiet");
    wd_en = 1'b1;
    step(T - 1);
    expect_rst(1'b0, "R8 full timeout after enable (before)");
    step(1);
    expect_rst(1'b1, "R8 full timeout after enable (fire)");
    step(P);
  endtask

  task automatic t_pg_restart();
    supply_low = 1'b1; step(2);
    expect_rst(1'b1, "R1 supply drop");
    supply_low = 1'b0; step(PG/2);
    expect_rst(1'b1, "R2 mid hold-off");
    supply_low = 1'b1; step(1);
    expect_rst(1'b1, "R1 dip during hold-off");
    supply_low = 1'b0;
    step(PG - 1);
    expect_rst(1'b1, "R3 restarted hold-off (before)");
    step(1);
    expect_rst(1'b0, "R3 restarted hold-off (release)");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_pg_release();
    t_stuck_high();
    t_stuck_low();
    t_kick();
    t_disable();
    t_pg_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule